// File: doc/BRIEF.md
# Multi-bank clock divider with glitch-free reselect

This block divides one fast input clock, which stands in for an oscillator, into three banks of four clock outputs (A, B and C) and a single feedback output. Each bank and the feedback output has its own table of even divide ratios, selected by small select codes. A shared prescale control either doubles every ratio (the input is halved first) or leaves the ratios as tabled. Every output runs at a 50% duty cycle counted in input clock cycles, and rises on a rising edge of the input clock.

Select inputs may change while the block is running. They pass through a two-flop synchronizer, and each divider adopts a new ratio only when it starts a new period, at the rising edge of its output. Every output period is therefore a complete old period or a complete new period, never a runt or a stretched one. A separate input inverts the upper two outputs of bank C. The inversion is applied in the same output register stage as all other outputs, so it adds no skew. An active-low asynchronous master reset clears every flop and holds all outputs low.

Two kinds of state machine make up the block. The start sequencer has states TS_SYNC1, TS_SYNC2 and TS_RUN, with the transitions reset→TS_SYNC1, TS_SYNC1→TS_SYNC2 (first synchronizer stage filled), TS_SYNC2→TS_RUN (selects valid) and TS_RUN→TS_RUN. Each of the four dividers has states DV_IDLE, DV_HIGH and DV_LOW. Its transitions are DV_IDLE→DV_HIGH (run seen, ratio loaded), DV_HIGH→DV_LOW (high half done), DV_LOW→DV_HIGH (period done, ratio reloaded) and, within each phase, countdown self-loops.

Top module: `clkdiv_banks`

## Requirements
- R1: Bank A period in input cycles, with bypass_pre=1, is 4, 6, 8 or 12 for sel_a = 0, 1, 2, 3. With bypass_pre=0 every value doubles (8, 12, 16, 24).
- R2: Bank B period, with bypass_pre=1, is 4, 6, 8 or 10 for sel_b = 0..3. With bypass_pre=0 the periods are 8, 12, 16 and 20.
- R3: Bank C period, with bypass_pre=1, is 2, 4, 6 or 8 for sel_c = 0..3. With bypass_pre=0 the periods are 4, 8, 12 and 16.
- R4: The feedback period, with bypass_pre=0, is 8, 12, 16, 20, 16, 24, 32 or 40 for sel_fb = 0..7. With bypass_pre=1 each of these is halved.
- R5: Every output is high for exactly half of its period in input cycles.
- R6: After any change of sel_a, sel_b, sel_c, sel_fb or bypass_pre, each output period and high time is either the old value or the new value. The new ratio is in force at most two input cycles plus one old period later.
- R7: While inv_c=1, qc[2] and qc[3] are the complement of qc[0] on every cycle. While inv_c=0 they equal qc[0]. qc[1] always equals qc[0].
- R8: While rst_n=0 all outputs are 0. After rst_n rises, all outputs stay 0 through the third rising clock edge and are all 1 after the fourth.
- R9: The four outputs of bank A are identical on every cycle, and so are the four outputs of bank B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Active-low asynchronous master reset |
| bypass_pre | input | 1 | 1: tabled ratios; 0: all ratios doubled |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_c | input | 2 | Bank C ratio code |
| sel_fb | input | 3 | Feedback ratio code |
| inv_c | input | 1 | Inverts the upper bank C outputs |
| qa | output | 4 | Bank A clock outputs |
| qb | output | 4 | Bank B clock outputs |
| qc | output | 4 | Bank C clock outputs |
| fb_out | output | 1 | Feedback clock output |

## Verification
On every cycle, the assertions check three things: outputs are low under reset, the bank outputs stay identical, and the bank C outputs pair up. They also check that a divider changes its latched ratio only on the edge where its output rises, and that its countdown never exceeds the latched half period. The divide ratios and the 50% duty cycle are left to the bench, since only it knows the expected ratio for each select code. So are the bounds on every period around a reselect and the exact start-up edge, which the bench checks over an exhaustive sweep of codes and of old-to-new transitions.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CNT_W = 5;

    typedef enum logic [1:0] {CH_A = 2'd0, CH_B = 2'd1, CH_C = 2'd2, CH_FB = 2'd3} chan_e;
    typedef enum logic [1:0] {DV_IDLE, DV_HIGH, DV_LOW} div_state_e;
    typedef enum logic [1:0] {TS_SYNC1, TS_SYNC2, TS_RUN} top_state_e;

    // Half period in input cycles for a channel, code and prescale setting.
    function automatic logic [CNT_W-1:0] half_len(input chan_e ch, input logic bypass,
                                                  input logic [2:0] code);
        logic [CNT_W-1:0] h;
        h = CNT_W'(2);
        unique case (ch)
            CH_A: begin
                unique case (code[1:0])
                    2'd0: h = CNT_W'(2);
                    2'd1: h = CNT_W'(3);
                    2'd2: h = CNT_W'(4);
                    2'd3: h = CNT_W'(6);
                endcase
            end
            CH_B: begin
                unique case (code[1:0])
                    2'd0: h = CNT_W'(2);
                    2'd1: h = CNT_W'(3);
                    2'd2: h = CNT_W'(4);
                    2'd3: h = CNT_W'(5);
                endcase
            end
            CH_C: begin
                unique case (code[1:0])
                    2'd0: h = CNT_W'(1);
                    2'd1: h = CNT_W'(2);
                    2'd2: h = CNT_W'(3);
                    2'd3: h = CNT_W'(4);
                endcase
            end
            CH_FB: begin
                unique case (code)
                    3'd0: h = CNT_W'(2);
                    3'd1: h = CNT_W'(3);
                    3'd2: h = CNT_W'(4);
                    3'd3: h = CNT_W'(5);
                    3'd4: h = CNT_W'(4);
                    3'd5: h = CNT_W'(6);
                    3'd6: h = CNT_W'(8);
                    3'd7: h = CNT_W'(10);
                endcase
            end
        endcase
        return bypass ? h : (h << 1);
    endfunction

endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q        <= '0;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end

endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
    import clkdiv_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] half_new,
    output logic          div_o
);

    div_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] half_q, half_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= DV_IDLE;
            cnt_q  <= '0;
            half_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            half_q <= half_d;
        end
    end

    // Next state: a ratio is taken only when a new period begins
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        half_d = half_q;
        unique case (st_q)
            DV_IDLE: begin
                if (run) begin
                    st_d   = DV_HIGH;
                    half_d = half_new;
                    cnt_d  = half_new - CW'(1);
                end
            end
            DV_HIGH: begin
                if (cnt_q == '0) begin
                    st_d  = DV_LOW;
                    cnt_d = half_q - CW'(1);
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            DV_LOW: begin
                if (cnt_q == '0) begin
                    st_d   = DV_HIGH;
                    half_d = half_new;
                    cnt_d  = half_new - CW'(1);
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: st_d = DV_IDLE;
        endcase
    end

    // Output
    always_comb begin
        div_o = (st_q == DV_HIGH);
    end

    // R6: latched ratio only moves on the edge that starts a high phase
    a_r6_adopt_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (half_q != $past(half_q)) |-> $rose(div_o));

    // R5: countdown stays within the latched half period
    a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != DV_IDLE) |-> (cnt_q < half_q));

endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks
    import clkdiv_pkg::*;
#(
    parameter int N_OUT     = 4,
    parameter int INV_FIRST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass_pre,
    input  logic [1:0]       sel_a,
    input  logic [1:0]       sel_b,
    input  logic [1:0]       sel_c,
    input  logic [2:0]       sel_fb,
    input  logic             inv_c,
    output logic [N_OUT-1:0] qa,
    output logic [N_OUT-1:0] qb,
    output logic [N_OUT-1:0] qc,
    output logic             fb_out
);

    localparam int CW     = CNT_W;
    localparam int SEL_W  = 2;
    localparam int FBS_W  = 3;
    localparam int N_CH   = 4;
    localparam int SYNC_W = 3 * SEL_W + FBS_W + 2;

    logic [SYNC_W-1:0] raw_sel, syn_sel;
    logic [2:0]        code [N_CH];
    logic              pre_s, inv_s;

    assign raw_sel = {inv_c, bypass_pre, sel_fb, sel_c, sel_b, sel_a};

    clkdiv_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_sel),
        .q     (syn_sel)
    );

    assign code[CH_A]  = {1'b0, syn_sel[1:0]};
    assign code[CH_B]  = {1'b0, syn_sel[3:2]};
    assign code[CH_C]  = {1'b0, syn_sel[5:4]};
    assign code[CH_FB] = syn_sel[8:6];
    assign pre_s       = syn_sel[9];
    assign inv_s       = syn_sel[10];

    // Start sequencer
    top_state_e ts_q, ts_d;
    logic       run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= TS_SYNC1;
        else        ts_q <= ts_d;
    end

    always_comb begin
        ts_d = ts_q;
        unique case (ts_q)
            TS_SYNC1: ts_d = TS_SYNC2;
            TS_SYNC2: ts_d = TS_RUN;
            TS_RUN:   ts_d = TS_RUN;
            default:  ts_d = TS_SYNC1;
        endcase
    end

    assign run = (ts_q == TS_RUN);

    // Dividers
    logic [N_CH-1:0] div;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        logic [CW-1:0] half_new;
        assign half_new = half_len(chan_e'(ch), pre_s, code[ch]);
        clkdiv_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .half_new (half_new),
            .div_o    (div[ch])
        );
    end

    // Output stage: one register level for every output, inverted or not
    logic [N_OUT-1:0] qc_d;

    for (genvar i = 0; i < N_OUT; i++) begin : g_cout
        if (i >= INV_FIRST) begin : g_inv
            assign qc_d[i] = div[CH_C] ^ inv_s;
        end else begin : g_pass
            assign qc_d[i] = div[CH_C];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qa     <= '0;
            qb     <= '0;
            qc     <= '0;
            fb_out <= 1'b0;
        end else begin
            qa     <= {N_OUT{div[CH_A]}};
            qb     <= {N_OUT{div[CH_B]}};
            qc     <= qc_d;
            fb_out <= div[CH_FB];
        end
    end

    // R8: outputs low under reset
    a_r8_reset_low: assert property (@(posedge clk)
        !rst_n |-> (qa == '0 && qb == '0 && qc == '0 && !fb_out));

    // R9: bank outputs identical
    a_r9_bank_a_same: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(qa) == 0) || ($countones(qa) == N_OUT));
    a_r9_bank_b_same: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(qb) == 0) || ($countones(qb) == N_OUT));

    // R7: bank C splits into two groups of equal outputs
    a_r7_c_groups: assert property (@(posedge clk) disable iff (!rst_n)
        (($countones(qc[INV_FIRST-1:0]) == 0) || ($countones(qc[INV_FIRST-1:0]) == INV_FIRST)) &&
        (($countones(qc[N_OUT-1:INV_FIRST]) == 0) ||
         ($countones(qc[N_OUT-1:INV_FIRST]) == N_OUT - INV_FIRST)));

endmodule

// File: tb/clkdiv_banks_tb_top.sv
`timescale 1ns/1ps
module clkdiv_banks_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       bypass_pre = 1'b1;
    logic [1:0] sel_a = '0, sel_b = '0, sel_c = '0;
    logic [2:0] sel_fb = '0;
    logic       inv_c = 1'b0;
    logic [3:0] qa, qb, qc;
    logic       fb_out;

    always #2.5 clk = ~clk;

    clkdiv_banks dut_i (
        .clk(clk), .rst_n(rst_n), .bypass_pre(bypass_pre),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
        .inv_c(inv_c), .qa(qa), .qb(qb), .qc(qc), .fb_out(fb_out)
    );

    int errs = 0, checks = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Period / high-time monitor on qa[0], qb[0], qc[0], fb_out
    int cyc = 0;
    logic [3:0] prev = '0, mon;
    int last_rise [4], per [4], hi [4], nrise [4];
    int pmin [4], pmax [4], hmin [4], hmax [4];

    always @(negedge clk) begin
        cyc++;
        mon = {fb_out, qc[0], qb[0], qa[0]};
        for (int i = 0; i < 4; i++) begin
            if (mon[i] && !prev[i]) begin
                if (nrise[i] > 0) begin
                    per[i] = cyc - last_rise[i];
                    if (per[i] < pmin[i]) pmin[i] = per[i];
                    if (per[i] > pmax[i]) pmax[i] = per[i];
                end
                last_rise[i] = cyc;
                nrise[i]++;
            end
            if (!mon[i] && prev[i] && nrise[i] > 0) begin
                hi[i] = cyc - last_rise[i];
                if (hi[i] < hmin[i]) hmin[i] = hi[i];
                if (hi[i] > hmax[i]) hmax[i] = hi[i];
            end
        end
        prev = mon;
    end

    task automatic clear_minmax();
        for (int i = 0; i < 4; i++) begin
            pmin[i] = 1000; pmax[i] = 0; hmin[i] = 1000; hmax[i] = 0;
        end
    endtask

    // Expected period from the requirement tables, computed arithmetically
    function automatic int exp_n(input int ch, input bit byp, input int code, input int fbc);
        int b;
        case (ch)
            0: b = (code == 3) ? 12 : 4 + 2 * code;
            1: b = 4 + 2 * code;
            2: b = 2 + 2 * code;
            default: b = (4 + 2 * (fbc % 4)) * ((fbc >= 4) ? 2 : 1);
        endcase
        return byp ? b : 2 * b;
    endfunction

    function automatic string req_of(input int ch);
        case (ch)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic set_cfg(input bit byp, input int code, input int fbc);
        bypass_pre = byp;
        sel_a = 2'(code); sel_b = 2'(code); sel_c = 2'(code);
        sel_fb = 3'(fbc);
    endtask

    // Reset, then check the start edge (R8)
    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk({qa, qb, qc, fb_out} == '0, "R8 reset low", int'({qa, qb, qc, fb_out}), 0);
        for (int i = 0; i < 4; i++) nrise[i] = 0;
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({fb_out, qc[0], qb[0], qa[0]} == 4'h0, "R8 low through third edge",
            int'({fb_out, qc[0], qb[0], qa[0]}), 0);
        @(negedge clk);
        chk({fb_out, qc[0], qb[0], qa[0]} == 4'hF, "R8 all rise on fourth edge",
            int'({fb_out, qc[0], qb[0], qa[0]}), 15);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        clear_minmax();
        for (int i = 0; i < 4; i++) begin
            nrise[i] = 0; last_rise[i] = 0; per[i] = 0; hi[i] = 0;
        end

        // Sweep of all ratio codes with both prescale settings: R1..R5, R9
        for (int byp = 0; byp < 2; byp++) begin
            for (int code = 0; code < 4; code++) begin
                for (int fbh = 0; fbh < 2; fbh++) begin
                    int fbc;
                    int mism;
                    fbc = code + 4 * fbh;
                    set_cfg(bit'(byp), code, fbc);
                    do_reset();
                    mism = 0;
                    repeat (120) begin
                        @(negedge clk);
                        if (!(qa == 4'h0 || qa == 4'hF) || !(qb == 4'h0 || qb == 4'hF)) mism++;
                    end
                    chk(mism == 0, "R9 bank outputs identical", mism, 0);
                    for (int ch = 0; ch < 4; ch++) begin
                        int n;
                        n = exp_n(ch, bit'(byp), code, fbc);
                        chk(per[ch] == n, req_of(ch), per[ch], n);
                        chk(hi[ch] == n / 2, "R5 duty", hi[ch], n / 2);
                    end
                end
            end
        end

        // Every old-to-new transition of code and prescale: R6
        for (int ko = 0; ko < 8; ko++) begin
            for (int kn = 0; kn < 8; kn++) begin
                if (kn != ko) begin
                    bit bo, bn;
                    int co, cn, fo, fn;
                    bo = ko[2]; co = ko % 4; fo = (ko * 3) % 8;
                    bn = kn[2]; cn = kn % 4; fn = (kn * 3) % 8;
                    set_cfg(bo, co, fo);
                    do_reset();
                    repeat (120) @(negedge clk);
                    clear_minmax();
                    repeat ((ko + kn) % 7 + 1) @(negedge clk);
                    set_cfg(bn, cn, fn);
                    repeat (130) @(negedge clk);
                    for (int ch = 0; ch < 4; ch++) begin
                        int no, nn, lo, hb;
                        no = exp_n(ch, bo, co, fo);
                        nn = exp_n(ch, bn, cn, fn);
                        lo = (no < nn) ? no : nn;
                        hb = (no > nn) ? no : nn;
                        chk(pmin[ch] >= lo, "R6 no runt period", pmin[ch], lo);
                        chk(pmax[ch] <= hb, "R6 no stretched period", pmax[ch], hb);
                        chk(hmin[ch] >= lo / 2, "R6 no runt high", hmin[ch], lo / 2);
                        chk(hmax[ch] <= hb / 2, "R6 no stretched high", hmax[ch], hb / 2);
                        chk(per[ch] == nn, "R6 new ratio adopted", per[ch], nn);
                    end
                end
            end
        end

        // Inversion of the upper bank C outputs: R7
        set_cfg(1'b1, 1, 2);
        do_reset();
        repeat (10) @(negedge clk);
        for (int iv = 0; iv < 2; iv++) begin
            int bad, rises;
            logic q0p;
            @(negedge clk) inv_c = bit'(iv == 0);
            repeat (5) @(negedge clk);
            bad = 0; rises = 0; q0p = qc[0];
            repeat (60) begin
                @(negedge clk);
                if (qc[0] && !q0p) rises++;
                q0p = qc[0];
                if (qc[1] != qc[0]) bad++;
                if (qc[2] != (qc[0] ^ inv_c) || qc[3] != (qc[0] ^ inv_c)) bad++;
            end
            chk(bad == 0, "R7 upper C outputs follow inv_c with no skew", bad, 0);
            chk(rises >= 10, "R7 bank C still toggling", rises, 15);
        end

        // Asynchronous reset while outputs are high, inversion active: R8
        @(negedge clk) inv_c = 1'b1;
        repeat (8) @(negedge clk);
        while (!qa[0]) @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        chk({qa, qb, qc, fb_out} == '0, "R8 reset forces outputs low", int'({qa, qb, qc, fb_out}), 0);
        repeat (3) @(negedge clk);
        chk({qa, qb, qc, fb_out} == '0, "R8 outputs held low in reset", int'({qa, qb, qc, fb_out}), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule